// File: doc/BRIEF.md
# Supervisory Reset Pulse Controller

This block is the digital core of a supply supervisor's reset generator. It takes a power-good flag from an external threshold comparator, a one-cycle timeout strobe from a watchdog, and two board-level reset requests: one active-high and one active-low. From these it produces a single reset state. That state is driven out twice, once active-high and once active-low, and the two outputs always agree.

Both outputs are asserted while power is not good. When power becomes good, the block holds reset for a fixed stretch of clock ticks before releasing it. A watchdog strobe, a rising edge on the active-high request or a falling edge on the active-low request each start a full stretch. A trigger that arrives during a stretch restarts the count from zero. Because of this, the block also works as a debounce and reset-extender circuit for noisy push-button inputs.

The control is a three-state machine:
- `ST_PWR_LOW`: power not good.
- `ST_STRETCH`: holding reset while the counter runs.
- `ST_RUN`: reset released.

The transitions are:
- Any state goes to `ST_PWR_LOW` when power-good is low.
- `ST_PWR_LOW` goes to `ST_STRETCH` when power-good is sampled high.
- `ST_STRETCH` stays in `ST_STRETCH` on a trigger, with the counter restarted.
- `ST_STRETCH` goes to `ST_RUN` when the count expires.
- `ST_RUN` goes to `ST_STRETCH` on a trigger.

Top module: `supv_reset_ctrl`

## Requirements
- R1: While `pwr_good_i` is 0, `sys_rst_o` is 1 in the same cycle, with no clock edge needed.
- R2: After the first rising clock edge that samples `pwr_good_i` high, reset stays asserted for exactly `STRETCH_TICKS` cycles and is released after the `STRETCH_TICKS`-th following edge.
- R3: If `pwr_good_i` falls during the run or during a stretch, reset asserts in that same cycle. When power returns, a complete new stretch follows.
- R4: `sys_rst_n_o` is always the inverse of `sys_rst_o`.
- R5: A 0-to-1 transition on `ext_rst_hi_i` passes through a two-flop synchronizer and an edge detector. Reset asserts after the third rising edge following the change and lasts `STRETCH_TICKS` cycles.
- R6: A 1-to-0 transition on `ext_rst_lo_n_i` has the same effect and the same three-edge latency as R5.
- R7: `wdt_timeout_i` sampled 1 at a rising edge while power is good asserts reset after that edge for `STRETCH_TICKS` cycles.
- R8: A trigger arriving during a stretch restarts the count from zero. Reset is then released `STRETCH_TICKS` edges after the edge that saw the new trigger.
- R9: Holding an external request at its active level gives only one stretch. A falling edge on `ext_rst_hi_i` and a rising edge on `ext_rst_lo_n_i` do not assert reset.
- R10: The synchronous block reset `rst` puts the block in the power-low state with the counter cleared. Reset is asserted after the edge that samples `rst`, and a full stretch follows its release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset of the block itself |
| pwr_good_i | input | 1 | Power-good flag from the threshold comparator, already synchronous |
| wdt_timeout_i | input | 1 | One-cycle watchdog timeout strobe, synchronous |
| ext_rst_hi_i | input | 1 | Asynchronous active-high external reset request, rising-edge triggered |
| ext_rst_lo_n_i | input | 1 | Asynchronous active-low external reset request, falling-edge triggered |
| sys_rst_o | output | 1 | System reset, active high |
| sys_rst_n_o | output | 1 | System reset, active low |

## Verification
A low power-good asserts the outputs with zero latency. A watchdog strobe takes effect one edge after it is sampled. An external request edge takes effect three edges after it is sampled. Release comes `STRETCH_TICKS` edges after the edge that entered or restarted the stretch.

The bench drives every input 5 ns after a rising edge. Its behavioural model advances on the rising edge, and the outputs are compared with the model on each falling edge. This timing means each of these latencies is checked in the exact cycle it is due, never one early or one late.

// File: rtl/supv_pkg.sv
package supv_pkg;

    typedef enum logic [1:0] {
        ST_PWR_LOW = 2'd0,
        ST_STRETCH = 2'd1,
        ST_RUN     = 2'd2
    } supv_state_e;

endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
    parameter int unsigned     WIDTH   = 2,
    parameter int unsigned     STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [WIDTH-1:0] stage_d;
        if (s == 0) begin : g_first
            assign stage_d = d_i;
        end else begin : g_next
            assign stage_d = stage_q[s-1];
        end
        always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= RST_VAL;
            else     stage_q[s] <= stage_d;
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/supv_edge_detect.sv
module supv_edge_detect #(
    parameter int unsigned      WIDTH     = 2,
    parameter logic [WIDTH-1:0] RISE_MASK = '1,
    parameter logic [WIDTH-1:0] RST_VAL   = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] lvl_i,
    output logic [WIDTH-1:0] edge_o
);

    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= RST_VAL;
        else     prev_q <= lvl_i;
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (RISE_MASK[i]) begin : g_rise
            assign edge_o[i] = lvl_i[i] & ~prev_q[i];
        end else begin : g_fall
            assign edge_o[i] = ~lvl_i[i] & prev_q[i];
        end
    end

endmodule

// File: rtl/supv_stretch_cnt.sv
module supv_stretch_cnt #(
    parameter int unsigned TICKS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    output logic done_o
);

    localparam int unsigned CW = $clog2(TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt_q;

    assign done_o = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr_i)  cnt_q <= '0;
        else if (!done_o)  cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/supv_reset_ctrl.sv
module supv_reset_ctrl
    import supv_pkg::*;
#(
    parameter int unsigned STRETCH_TICKS = 10_000_000,
    parameter int unsigned SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_good_i,
    input  logic wdt_timeout_i,
    input  logic ext_rst_hi_i,
    input  logic ext_rst_lo_n_i,
    output logic sys_rst_o,
    output logic sys_rst_n_o
);

    localparam int unsigned  NUM_EXT   = 2;
    localparam logic [1:0]   EXT_IDLE  = 2'b10;
    localparam logic [1:0]   EXT_RISE  = 2'b01;

    supv_state_e      state_q, state_d;
    logic [NUM_EXT-1:0] ext_sync, ext_edge;
    logic             trig;
    logic             cnt_clr, cnt_done;
    logic             rst_active;

    supv_sync #(
        .WIDTH  (NUM_EXT),
        .STAGES (SYNC_STAGES),
        .RST_VAL(EXT_IDLE)
    ) sync_i (
        .clk  (clk),
        .rst  (rst),
        .d_i  ({ext_rst_lo_n_i, ext_rst_hi_i}),
        .q_o  (ext_sync)
    );

    supv_edge_detect #(
        .WIDTH    (NUM_EXT),
        .RISE_MASK(EXT_RISE),
        .RST_VAL  (EXT_IDLE)
    ) edge_i (
        .clk   (clk),
        .rst   (rst),
        .lvl_i (ext_sync),
        .edge_o(ext_edge)
    );

    assign trig = wdt_timeout_i | (|ext_edge);

    assign cnt_clr = (state_q != ST_STRETCH) | trig;

    supv_stretch_cnt #(
        .TICKS(STRETCH_TICKS)
    ) cnt_i (
        .clk   (clk),
        .rst   (rst),
        .clr_i (cnt_clr),
        .done_o(cnt_done)
    );

    always_comb begin
        state_d = state_q;
        if (!pwr_good_i) begin
            state_d = ST_PWR_LOW;
        end else begin
            unique case (state_q)
                ST_PWR_LOW: state_d = ST_STRETCH;
                ST_STRETCH: begin
                    if (trig)          state_d = ST_STRETCH;
                    else if (cnt_done) state_d = ST_RUN;
                end
                ST_RUN:     if (trig) state_d = ST_STRETCH;
                default:    state_d = ST_PWR_LOW;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_PWR_LOW;
        else     state_q <= state_d;
    end

    always_comb begin
        rst_active  = (state_q != ST_RUN) | ~pwr_good_i;
        sys_rst_o   = rst_active;
        sys_rst_n_o = ~rst_active;
    end

endmodule

// File: rtl/supv_reset_chk.sv
module supv_reset_chk #(
    parameter int unsigned STRETCH_TICKS = 10_000_000
) (
    input logic clk,
    input logic rst,
    input logic pwr_good_i,
    input logic wdt_timeout_i,
    input logic sys_rst_o,
    input logic sys_rst_n_o
);

    int unsigned held_len;

    always_ff @(posedge clk) begin
        if (rst || !pwr_good_i || !sys_rst_o) held_len <= 0;
        else if (held_len < STRETCH_TICKS + 2) held_len <= held_len + 1;
    end

    // R1
    pwr_low_assert_chk: assert property (@(posedge clk) disable iff (rst)
        !pwr_good_i |-> (sys_rst_o && !sys_rst_n_o));

    // R7
    wdt_assert_chk: assert property (@(posedge clk) disable iff (rst)
        (wdt_timeout_i && pwr_good_i) |=> sys_rst_o);

    // R10
    self_reset_chk: assert property (@(posedge clk)
        rst |=> sys_rst_o);

    // R2
    pwr_rise_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_good_i) |-> sys_rst_o);

    // R8
    stretch_min_chk: assert property (@(posedge clk) disable iff (rst)
        (!sys_rst_o && $past(sys_rst_o)) |-> (held_len >= STRETCH_TICKS));

endmodule

bind supv_reset_ctrl supv_reset_chk #(.STRETCH_TICKS(STRETCH_TICKS)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .pwr_good_i   (pwr_good_i),
    .wdt_timeout_i(wdt_timeout_i),
    .sys_rst_o    (sys_rst_o),
    .sys_rst_n_o  (sys_rst_n_o)
);

// File: tb/supv_reset_ctrl_tb.sv
`timescale 1ns/1ps
module supv_reset_ctrl_tb_top;

    localparam int unsigned N = 12;

    logic clk = 1'b0;
    logic rst, pwr_good, wdt, ext_hi, ext_lo_n;
    logic sys_rst, sys_rst_n;

    int checks = 0;
    int failures = 0;
    string cur_req = "R10";
    bit finished = 1'b0;

    always #10 clk = ~clk;

    supv_reset_ctrl #(.STRETCH_TICKS(N)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .pwr_good_i    (pwr_good),
        .wdt_timeout_i (wdt),
        .ext_rst_hi_i  (ext_hi),
        .ext_rst_lo_n_i(ext_lo_n),
        .sys_rst_o     (sys_rst),
        .sys_rst_n_o   (sys_rst_n)
    );

    // Behavioural reference: 0 = power low, 1 = stretching, 2 = running
    int m_mode = 0;
    int m_left = 0;
    bit hq[$] = '{1'b0, 1'b0, 1'b0};
    bit lq[$] = '{1'b1, 1'b1, 1'b1};

    always @(posedge clk) begin
        bit t;
        if (rst) begin
            m_mode = 0;
            hq = '{1'b0, 1'b0, 1'b0};
            lq = '{1'b1, 1'b1, 1'b1};
        end else begin
            t = wdt || (hq[1] && !hq[2]) || (!lq[1] && lq[2]);
            if (!pwr_good) m_mode = 0;
            else if (m_mode == 0) begin m_mode = 1; m_left = N; end
            else if (m_mode == 1) begin
                if (t) m_left = N;
                else begin
                    m_left = m_left - 1;
                    if (m_left == 0) m_mode = 2;
                end
            end else if (t) begin m_mode = 1; m_left = N; end
            hq.push_front(ext_hi); void'(hq.pop_back());
            lq.push_front(ext_lo_n); void'(lq.pop_back());
        end
    end

    task automatic check(input bit ok, input string req, input logic act, input logic exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        logic exp;
        if (!finished) begin
            exp = (m_mode != 2) || !pwr_good;
            check(sys_rst === exp, cur_req, sys_rst, exp);
            check(sys_rst_n === ~sys_rst, "R4", sys_rst_n, ~sys_rst);
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #5;
        end
    endtask

    task automatic wdt_pulse();
        wdt = 1'b1; cyc(1); wdt = 1'b0;
    endtask

    initial begin
        rst = 1'b1; pwr_good = 1'b0; wdt = 1'b0; ext_hi = 1'b0; ext_lo_n = 1'b1;
        cur_req = "R10"; cyc(3);
        rst = 1'b0; cur_req = "R1"; cyc(5);
        pwr_good = 1'b1; cur_req = "R2"; cyc(N + 6);
        cur_req = "R7"; wdt_pulse(); cyc(N + 5);
        cur_req = "R5"; ext_hi = 1'b1; cyc(N + 6);
        cur_req = "R9"; cyc(N + 6); ext_hi = 1'b0; cyc(N + 6);
        cur_req = "R6"; ext_lo_n = 1'b0; cyc(N + 6);
        cur_req = "R9"; cyc(N + 6); ext_lo_n = 1'b1; cyc(N + 6);
        cur_req = "R8"; wdt_pulse(); cyc(5); wdt_pulse(); cyc(7);
        ext_hi = 1'b1; cyc(2); ext_hi = 1'b0; cyc(N + 6);
        cur_req = "R3"; pwr_good = 1'b0; cyc(3); pwr_good = 1'b1; cyc(4);
        pwr_good = 1'b0; cyc(1); pwr_good = 1'b1; cyc(N + 6);
        cur_req = "R10"; rst = 1'b1; cyc(2); rst = 1'b0; cyc(N + 6);
        cur_req = "R7"; pwr_good = 1'b0; wdt_pulse(); pwr_good = 1'b1; cyc(N + 4);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        cyc(200000);
        if (!finished) begin
            finished = 1'b1;
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule